// File: doc/BRIEF.md
# Scheduled Load-Increment-Store Memory Node

This block is the memory-touching part of a statically scheduled subcircuit that carries out the statement "read the word at one address, add one, write it to another address". A single control token, launched by a start pulse, walks through a fixed chain of schedule slots. Each slot belongs to exactly one operation node. The load address node, the load data node, the incrementer and the store node each act only while the token sits in their own slot.

All memory traffic uses one shared interface: an address bus, a write-data bus, a read request and a write request. The load is split into two nodes. The first presents the source address and raises the read request. In the next slot the second node takes the returned word. If the memory has not flagged the word as valid by then, the whole subcircuit stalls. The token and every register hold their values until the valid flag arrives. A predicate latched at start gates the store trigger, so a store on a branch that was not taken leaves memory untouched. A node outside its slot drives zeros, which lets the drivers be merged onto the shared buses with a plain OR.

Top module: `mem_rmw_node`

## Requirements
- R1: After reset the node is idle: `mem_rd`, `mem_wr`, `done` and `busy` are 0, and `mem_addr` and `mem_wdata` are 0.
- R2: A `start` pulse seen at a clock edge while idle latches `src_addr`, `dst_addr` and `pred`. In the following cycle (slot 0) the node drives `mem_addr` = source address and `mem_rd` = 1, with `mem_wr` = 0 and `mem_wdata` = 0.
- R3: In slot 1 the node captures `mem_rdata` at the clock edge where `mem_rvalid` is 1. For each cycle of slot 1 with `mem_rvalid` low, the token chain and all state hold, and completion is delayed by one cycle.
- R4: With no stall, the store slot is the fourth cycle after the start edge (slot 3). In that cycle, with the predicate set, the node drives `mem_addr` = destination, `mem_wdata` = loaded word + 1 modulo 2^DW, and `mem_wr` = 1.
- R5: With the predicate clear, the store slot raises no write request and drives zero on both buses. Memory is unchanged after the operation.
- R6: Outside its slot every node drives zero. `mem_rd` and `mem_wr` are never 1 in the same cycle. In every cycle without a request, including stall cycles, both buses read 0.
- R7: `done` is a one-cycle pulse in the fifth cycle after the start edge plus the number of stall cycles. `busy` is 1 from the cycle after the start edge through the `done` cycle, and 0 afterwards.
- R8: A `start` pulse while `busy` is 1 is ignored. The operation in flight keeps its addresses, predicate and timing.
- R9: When source and destination are the same address, the load is issued before the store. The location ends up holding its old value + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches the control token when idle |
| src_addr | input | AW | Address to be loaded |
| dst_addr | input | AW | Address to be stored |
| pred | input | 1 | Branch predicate that enables the store |
| mem_addr | output | AW | Shared address bus |
| mem_wdata | output | DW | Shared write-data bus |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_rdata | input | DW | Returned load data |
| mem_rvalid | input | 1 | Load data valid; low in the capture slot stalls the node |
| busy | output | 1 | Token present in the chain |
| done | output | 1 | One-cycle completion pulse |

## Verification
Several properties are checked on every cycle. Read and write requests are mutually exclusive. Idle buses read zero. At most one slot holds the token. A stall freezes the token. The captured word equals the bus value at the capture edge. Writes only happen under a set predicate, and `done` is a single pulse. Other behaviour can only be shown by the bench's scenarios with a latency-varying memory model. These are the exact cycle of each bus phase relative to start, the length of the stall stretch, the final memory contents (including the aliased-address case and wrap at the all-ones word), and that a start raised mid-operation leaves the running operation intact.

// File: rtl/mem_rmw_pkg.sv
package mem_rmw_pkg;
    // Schedule slot indices along the token chain
    localparam int SLOT_LDA  = 0;  // load address phase
    localparam int SLOT_LDD  = 1;  // load data capture
    localparam int SLOT_INC  = 2;  // increment
    localparam int SLOT_ST   = 3;  // store
    localparam int SLOT_FIN  = 4;  // completion
    localparam int N_SLOT    = 5;

    typedef struct packed {
        logic [N_SLOT-1:0] tok;
    } seq_state_t;
endpackage

// File: rtl/mem_rmw_seq.sv
module mem_rmw_seq
    import mem_rmw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stall,
    output logic [N_SLOT-1:0] tok,
    output logic              accept,
    output logic              busy,
    output logic              done
);
    seq_state_t st_d, st_q;

    always_comb begin
        busy   = |st_q.tok;
        accept = start && !busy;
        done   = st_q.tok[SLOT_FIN];
        st_d   = st_q;
        if (!stall) begin
            st_d.tok = {st_q.tok[N_SLOT-2:0], accept};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tok = st_q.tok;

    assert_single_token_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.tok));
    assert_stall_freezes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(st_q.tok));
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/mem_rmw_load.sv
module mem_rmw_load #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slot_a,
    input  logic          slot_d,
    input  logic [AW-1:0] src,
    input  logic [DW-1:0] rdata,
    input  logic          rvalid,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd,
    output logic          stall,
    output logic [DW-1:0] word
);
    typedef struct packed {
        logic [DW-1:0] word;
    } ld_state_t;

    ld_state_t st_d, st_q;

    always_comb begin
        bus_addr = slot_a ? src : '0;
        bus_rd   = slot_a;
        stall    = slot_d && !rvalid;
        st_d     = st_q;
        if (slot_d && rvalid) st_d.word = rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word = st_q.word;

    assert_capture_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_d && rvalid) |=> (word == $past(rdata)));
    assert_hold_in_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(word));
endmodule

// File: rtl/mem_rmw_inc.sv
module mem_rmw_inc #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slot,
    input  logic          stall,
    input  logic [DW-1:0] word,
    output logic [DW-1:0] sum
);
    localparam logic [DW-1:0] ONE = DW'(1);

    typedef struct packed {
        logic [DW-1:0] sum;
    } inc_state_t;

    inc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (slot && !stall) st_d.sum = word + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sum = st_q.sum;

    assert_inc_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot && !stall) |=> (sum == $past(word) + ONE));
endmodule

// File: rtl/mem_rmw_store.sv
module mem_rmw_store #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slot,
    input  logic          pred,
    input  logic [AW-1:0] dst,
    input  logic [DW-1:0] sum,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_wr
);
    logic fire;

    always_comb begin
        fire      = slot && pred;
        bus_wr    = fire;
        bus_addr  = fire ? dst : '0;
        bus_wdata = fire ? sum : '0;
    end

    assert_write_needs_pred_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> (pred && slot));
endmodule

// File: rtl/mem_rmw_node.sv
module mem_rmw_node
    import mem_rmw_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    input  logic          pred,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_rd,
    output logic          mem_wr,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_rvalid,
    output logic          busy,
    output logic          done
);
    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic          pred;
    } in_state_t;

    in_state_t in_d, in_q;

    logic [N_SLOT-1:0] tok;
    logic              accept;
    logic              stall;
    logic [AW-1:0]     ld_addr, st_addr;
    logic [DW-1:0]     word, sum, st_wdata;
    logic              ld_rd, st_wr;

    // Input latches: loaded only when the token is launched
    always_comb begin
        in_d = in_q;
        if (accept) begin
            in_d.src  = src_addr;
            in_d.dst  = dst_addr;
            in_d.pred = pred;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) in_q <= '0;
        else        in_q <= in_d;
    end

    mem_rmw_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .stall  (stall),
        .tok    (tok),
        .accept (accept),
        .busy   (busy),
        .done   (done)
    );

    mem_rmw_load #(.AW(AW), .DW(DW)) u_load (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_a   (tok[SLOT_LDA]),
        .slot_d   (tok[SLOT_LDD]),
        .src      (in_q.src),
        .rdata    (mem_rdata),
        .rvalid   (mem_rvalid),
        .bus_addr (ld_addr),
        .bus_rd   (ld_rd),
        .stall    (stall),
        .word     (word)
    );

    mem_rmw_inc #(.DW(DW)) u_inc (
        .clk   (clk),
        .rst_n (rst_n),
        .slot  (tok[SLOT_INC]),
        .stall (stall),
        .word  (word),
        .sum   (sum)
    );

    mem_rmw_store #(.AW(AW), .DW(DW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot      (tok[SLOT_ST]),
        .pred      (in_q.pred),
        .dst       (in_q.dst),
        .sum       (sum),
        .bus_addr  (st_addr),
        .bus_wdata (st_wdata),
        .bus_wr    (st_wr)
    );

    // Shared bus: nodes drive zero outside their slot, so OR merges them
    always_comb begin
        mem_addr  = ld_addr | st_addr;
        mem_wdata = st_wdata;
        mem_rd    = ld_rd;
        mem_wr    = st_wr;
    end

    assert_bus_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    assert_quiet_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd || mem_wr) |-> (mem_addr == '0 && mem_wdata == '0));
    assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(in_q));
    assert_read_then_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (tok[SLOT_LDD] && !mem_rd));
endmodule

// File: tb/mem_rmw_node_bench.sv
module mem_rmw_node_bench;
    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] src_addr = '0;
    logic [AW-1:0] dst_addr = '0;
    logic          pred = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_rd, mem_wr;
    logic [DW-1:0] mem_rdata;
    logic          mem_rvalid;
    logic          busy, done;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    mem_rmw_node #(.AW(AW), .DW(DW)) u_mem_rmw_node (
        .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr),
        .dst_addr(dst_addr), .pred(pred), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .busy(busy), .done(done)
    );

    // Memory model with per-operation latency
    logic [DW-1:0] mem_m [16];
    int            lat_cfg = 0;
    logic          pend = 1'b0;
    int            cnt = 0;
    logic [3:0]    raddr = '0;

    always @(posedge clk) begin
        if (mem_wr) mem_m[mem_addr[3:0]] <= mem_wdata;
        if (mem_rd) begin
            pend  <= 1'b1;
            cnt   <= lat_cfg;
            raddr <= mem_addr[3:0];
        end else if (pend && cnt != 0) begin
            cnt <= cnt - 1;
        end else if (pend) begin
            pend <= 1'b0;
        end
    end

    assign mem_rvalid = pend && (cnt == 0);
    assign mem_rdata  = mem_rvalid ? mem_m[raddr] : 16'hBAD0;

    function automatic logic [DW-1:0] inc_of(input logic [DW-1:0] v);
        return v + 16'd1;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] s, input logic [3:0] d, input bit p,
                          input int lat, input bit inject);
        logic [DW-1:0] old_s, old_d, exp_d;
        old_s = mem_m[s];
        old_d = mem_m[d];
        exp_d = p ? inc_of(old_s) : old_d;
        lat_cfg = lat;
        @(negedge clk);
        start = 1'b1; src_addr = AW'(s); dst_addr = AW'(d); pred = p;
        @(negedge clk);  // slot 0: address phase
        start = 1'b0;
        check(mem_rd && !mem_wr && mem_addr == AW'(s) && mem_wdata == '0,
              "R2", "load address phase", {mem_rd, mem_wr, mem_addr}, {2'b10, AW'(s)});
        check(busy, "R7", "busy after start", busy, 1);
        if (inject) begin
            start = 1'b1; src_addr = AW'(s ^ 4'hF); dst_addr = AW'(d ^ 4'hF); pred = ~p;
        end
        for (int c = 2; c <= 5 + lat; c++) begin
            @(negedge clk);
            start = 1'b0;
            if (c < 4 + lat) begin
                check(!mem_rd && !mem_wr && mem_addr == '0 && mem_wdata == '0 && !done,
                      (c <= 1 + lat) ? "R3" : "R6", "quiet bus", {mem_rd, mem_wr, mem_addr}, 0);
            end else if (c == 4 + lat) begin
                if (p)
                    check(mem_wr && !mem_rd && mem_addr == AW'(d) && mem_wdata == inc_of(old_s),
                          "R4", "store phase", {mem_wr, mem_addr, mem_wdata},
                          {1'b1, AW'(d), inc_of(old_s)});
                else
                    check(!mem_wr && mem_addr == '0 && mem_wdata == '0,
                          "R5", "gated store", {mem_wr, mem_addr}, 0);
                check(!done, "R7", "done early", done, 0);
            end else begin
                check(done && busy, "R7", "done pulse", {done, busy}, 2'b11);
            end
        end
        @(negedge clk);
        check(!done && !busy, "R7", "return to idle", {done, busy}, 0);
        check(mem_m[d] == exp_d, (s == d) ? "R9" : (p ? "R4" : "R5"),
              "memory contents", mem_m[d], exp_d);
        if (inject)
            check(mem_m[d ^ 4'hF] == ((d ^ 4'hF) == d ? exp_d : mem_m[d ^ 4'hF]) && !mem_rd,
                  "R8", "start while busy ignored", mem_rd, 0);
    endtask

    // Watchdog
    initial begin
        while (cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        fails++; tests++;
        $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) mem_m[i] = 16'($urandom);
        mem_m[5] = 16'hFFFF;
        repeat (3) @(negedge clk);
        check(!mem_rd && !mem_wr && mem_addr == '0 && mem_wdata == '0 && !busy && !done,
              "R1", "reset state", {mem_rd, mem_wr, busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!mem_rd && !mem_wr && !busy && !done, "R1", "idle after reset",
              {mem_rd, mem_wr, busy, done}, 0);

        run_op(4'd1, 4'd2, 1'b1, 0, 1'b0);   // plain case
        run_op(4'd3, 4'd4, 1'b1, 3, 1'b0);   // late data, R3
        run_op(4'd6, 4'd7, 1'b0, 1, 1'b0);   // predicate clear, R5
        run_op(4'd8, 4'd8, 1'b1, 2, 1'b0);   // aliased address, R9
        run_op(4'd5, 4'd9, 1'b1, 0, 1'b0);   // wrap at all-ones, R4
        run_op(4'd10, 4'd11, 1'b1, 1, 1'b1); // start while busy, R8

        for (int k = 0; k < 24; k++) begin
            run_op(4'($urandom_range(15)), 4'($urandom_range(15)),
                   1'($urandom_range(1)), $urandom_range(3), 1'($urandom_range(1)));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule